// File: doc/BRIEF.md
# Single-Level Paged Address Translator

This block turns a 16-bit virtual address into a 15-bit physical address through a page table of sixteen entries, all held in flip-flops. The upper four address bits pick a 4 KiB page and the lower twelve bits pass through unchanged as the offset. Each entry holds a 3-bit frame number and a valid ("present") flag. A present entry maps its page onto one of eight 4 KiB frames.

Software changes the table one entry per cycle through a write port. A write sets the frame number and the present flag together, so the same port maps, remaps and unmaps a page. Evicting a page takes two writes: one clears the present flag of the old page, and one points the new page at the freed frame.

Translation requests arrive with a valid strobe. One cycle later the block returns a registered response. The response holds either the physical address or a fault flag together with the number of the page that had no mapping.

Top module: `paged_xlate`

## Requirements
- R1: A synchronous active-high reset clears every present flag and drives `rsp_valid` low. After reset, a request to any page returns a fault.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high, and low otherwise.
- R3: For a request to a page whose entry is present, the response has `rsp_fault` = 0 and `rsp_paddr` = {frame[2:0], vaddr[11:0]}. The frame number occupies bits 14:12 and the offset occupies bits 11:0.
- R4: For a request to a page whose entry is not present, the response has `rsp_fault` = 1, `rsp_fault_page` = vaddr[15:12] and `rsp_paddr` = 0.
- R5: A response with no fault carries `rsp_fault_page` = 0.
- R6: A write with `tbl_we` = 1 stores `tbl_frame` and `tbl_present` into the entry selected by `tbl_page`. It takes effect on the next cycle. A request in the same cycle as the write is translated with the old entry.
- R7: Writing an entry with `tbl_present` = 0 unmaps that page, so later requests to it fault. A page can then be remapped onto the freed frame.
- R8: While `tbl_we` = 0, the values on `tbl_page`, `tbl_frame` and `tbl_present` have no effect on any entry.
- R9: While `rsp_valid` is low, `rsp_fault`, `rsp_paddr` and `rsp_fault_page` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_we | input | 1 | Table entry write enable |
| tbl_page | input | 4 | Page whose entry is written |
| tbl_frame | input | 3 | Frame number to store |
| tbl_present | input | 1 | Present flag to store |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_fault | output | 1 | Page fault on the responded request |
| rsp_paddr | output | 15 | Translated physical address |
| rsp_fault_page | output | 4 | Number of the faulting page |

## Verification
The bench uses the package defaults: 16-bit virtual addresses, 12-bit offsets and 3-bit frame numbers. With these sizes all sixteen pages can be visited in several table states: the fresh table after reset, a table mixing present and absent entries, and a table that has just been remapped.

Each page is probed at its lowest offset, its highest offset, a mid-page offset and an offset that depends on the page. Every frame number, every page number and both polarities of each offset bit therefore reach the outputs.

The remaining checks cover three boundary cases:
- a write and a request to the same page in the same cycle;
- strobes sent on the write port while the write enable is low;
- the evict-and-remap sequence.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    parameter int VA_W = 16;
    parameter int OFF_W = 12;
    parameter int FR_W = 3;

    localparam int PG_W = VA_W - OFF_W;
    localparam int PA_W = FR_W + OFF_W;
    localparam int N_PAGES = 1 << PG_W;

    typedef struct packed {
        logic            present;
        logic [FR_W-1:0] frame;
    } pte_t;

    typedef struct packed {
        logic            valid;
        logic            fault;
        logic [PA_W-1:0] paddr;
        logic [PG_W-1:0] fpage;
    } rsp_t;

    function automatic logic [PG_W-1:0] page_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/pgx_table.sv
module pgx_table
    import pgx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [PG_W-1:0] wr_page,
    input  pte_t            wr_pte,
    input  logic [PG_W-1:0] rd_page,
    output pte_t            rd_pte
);

    pte_t [N_PAGES-1:0] tbl_q;
    logic [N_PAGES-1:0] sel;

    // One-hot write select.
    always_comb begin
        sel = '0;
        if (wr_en) sel[wr_page] = 1'b1;
    end

    for (genvar g = 0; g < N_PAGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)         tbl_q[g] <= '0;
            else if (sel[g]) tbl_q[g] <= wr_pte;
        end
    end

    // Reads see the registered entry, so a write in the same cycle is not yet visible.
    assign rd_pte = tbl_q[rd_page];

    a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> tbl_q[$past(wr_page)] == $past(wr_pte));

    a_r8_no_write_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(tbl_q));

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) && !rst |-> tbl_q == '0);

endmodule

// File: rtl/pgx_lookup.sv
module pgx_lookup
    import pgx_pkg::*;
(
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  pte_t            pte,
    output rsp_t            rsp
);

    always_comb begin
        rsp = '0;
        if (req_valid) begin
            rsp.valid = 1'b1;
            if (pte.present) begin
                rsp.paddr = {pte.frame, offset_of(req_vaddr)};
            end else begin
                rsp.fault = 1'b1;
                rsp.fpage = page_of(req_vaddr);
            end
        end
    end

endmodule

// File: rtl/pgx_rsp_reg.sv
module pgx_rsp_reg
    import pgx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rsp_t d,
    output rsp_t q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !q.valid |-> (!q.fault && q.paddr == '0 && q.fpage == '0));

endmodule

// File: rtl/paged_xlate.sv
module paged_xlate
    import pgx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tbl_we,
    input  logic [PG_W-1:0] tbl_page,
    input  logic [FR_W-1:0] tbl_frame,
    input  logic            tbl_present,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [PA_W-1:0] rsp_paddr,
    output logic [PG_W-1:0] rsp_fault_page
);

    pte_t wr_pte;
    pte_t rd_pte;
    rsp_t rsp_d;
    rsp_t rsp_q;

    assign wr_pte = '{present: tbl_present, frame: tbl_frame};

    pgx_table u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tbl_we),
        .wr_page(tbl_page),
        .wr_pte (wr_pte),
        .rd_page(page_of(req_vaddr)),
        .rd_pte (rd_pte)
    );

    pgx_lookup u_lookup (
        .req_valid(req_valid),
        .req_vaddr(req_vaddr),
        .pte      (rd_pte),
        .rsp      (rsp_d)
    );

    pgx_rsp_reg u_rsp (
        .clk(clk),
        .rst(rst),
        .d  (rsp_d),
        .q  (rsp_q)
    );

    assign rsp_valid      = rsp_q.valid;
    assign rsp_fault      = rsp_q.fault;
    assign rsp_paddr      = rsp_q.paddr;
    assign rsp_fault_page = rsp_q.fpage;

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_fault || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    a_r4_fault_page: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_fault || (rsp_fault_page == $past(req_vaddr[VA_W-1:OFF_W])
                                      && rsp_paddr == '0)));

    a_r5_hit_no_page: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_fault_page == '0);

endmodule

// File: tb/sim_paged_xlate.sv
`timescale 1ns/1ps
module sim_paged_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_page = '0;
    logic [2:0]  tbl_frame = '0;
    logic        tbl_present = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [14:0] rsp_paddr;
    logic [3:0]  rsp_fault_page;

    int vectors = 0;
    int fails = 0;

    logic       m_pres [16];
    logic [2:0] m_frame [16];

    always #5 clk = ~clk;

    paged_xlate u0 (
        .clk(clk), .rst(rst),
        .tbl_we(tbl_we), .tbl_page(tbl_page), .tbl_frame(tbl_frame), .tbl_present(tbl_present),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_fault_page(rsp_fault_page)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check after the next rising edge.
    task automatic step(input string tag, input logic we, input logic [3:0] wp,
                        input logic [2:0] wf, input logic wpres,
                        input logic rv, input logic [15:0] va);
        logic [3:0] pg;
        logic       e_fault;
        logic [14:0] e_pa;
        logic [3:0]  e_fp;
        @(negedge clk);
        tbl_we = we; tbl_page = wp; tbl_frame = wf; tbl_present = wpres;
        req_valid = rv; req_vaddr = va;
        pg = va[15:12];
        e_fault = rv && !m_pres[pg];
        e_pa = (rv && m_pres[pg]) ? {m_frame[pg], va[11:0]} : 15'd0;
        e_fp = e_fault ? pg : 4'd0;
        @(posedge clk);
        #1;
        vectors++;
        cmp(tag, "rsp_valid", int'(rsp_valid), int'(rv));
        cmp(tag, "rsp_fault", int'(rsp_fault), int'(e_fault));
        cmp(tag, "rsp_paddr", int'(rsp_paddr), int'(e_pa));
        cmp(tag, "rsp_fault_page", int'(rsp_fault_page), int'(e_fp));
        if (we) begin
            m_pres[wp] = wpres;
            m_frame[wp] = wf;
        end
    endtask

    task automatic req(input string tag, input logic [15:0] va);
        step(tag, 1'b0, 4'd0, 3'd0, 1'b0, 1'b1, va);
    endtask

    task automatic wr(input string tag, input logic [3:0] p, input logic [2:0] f, input logic pr);
        step(tag, 1'b1, p, f, pr, 1'b0, 16'd0);
    endtask

    task automatic sweep(input string tag);
        logic [11:0] offs [4];
        offs[0] = 12'h000; offs[1] = 12'hFFF; offs[2] = 12'h7FF; offs[3] = 12'h800;
        for (int p = 0; p < 16; p++) begin
            for (int k = 0; k < 4; k++) req(tag, {p[3:0], offs[k]});
            req(tag, {p[3:0], 12'(p * 37 + 5)});
        end
    endtask

    task automatic exact(input string tag, input logic [15:0] va, input logic flt, input int pa);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; tbl_we = 1'b0;
        @(posedge clk);
        #1;
        vectors++;
        cmp(tag, "rsp_fault", int'(rsp_fault), int'(flt));
        cmp(tag, "rsp_paddr", int'(rsp_paddr), pa);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_pres[i] = 1'b0; m_frame[i] = 3'd0; end
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1; vectors++;
        cmp("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        sweep("R1 R4 fresh table faults");

        // Mixed table: R3, R4, R5
        for (int p = 0; p < 16; p++)
            wr("R6 program", p[3:0], 3'((p * 5 + 3) % 8), (p % 3) != 2);
        sweep("R3 R4 R5 mixed table");

        // R2, R9: idle cycle gives no response
        step("R2 R9 idle", 1'b0, 4'd0, 3'd0, 1'b0, 1'b0, 16'hFFFF);

        // Reference mapping and eviction sequence
        wr("R6", 4'd0, 3'd2, 1'b1);
        wr("R6", 4'd1, 3'd1, 1'b1);
        wr("R6", 4'd2, 3'd6, 1'b1);
        wr("R6", 4'd5, 3'd3, 1'b1);
        wr("R7", 4'd8, 3'd0, 1'b0);
        exact("R3 page2->frame6", 16'd8196, 1'b0, 24580);
        exact("R3 page0->frame2", 16'd1026, 1'b0, 9218);
        exact("R3 page5->frame3", 16'd20500, 1'b0, 12308);
        exact("R4 page8 unmapped", 16'd32780, 1'b1, 0);
        wr("R7 evict page1", 4'd1, 3'd1, 1'b0);
        wr("R7 remap page8", 4'd8, 3'd1, 1'b1);
        exact("R7 remapped page8", 16'd32780, 1'b0, 4108);
        req("R7 evicted page1", 16'd4096);

        // R6: same-cycle write and request use the old entry
        wr("R6", 4'd3, 3'd4, 1'b0);
        step("R6 same cycle old entry", 1'b1, 4'd3, 3'd7, 1'b1, 1'b1, 16'h3ABC);
        req("R6 next cycle new entry", 16'h3ABC);
        step("R6 same cycle unmap", 1'b1, 4'd3, 3'd0, 1'b0, 1'b1, 16'h3001);
        req("R6 R7 after unmap", 16'h3001);

        // R8: strobes with write enable low leave the table alone
        for (int p = 0; p < 16; p++)
            step("R8 we low", 1'b0, p[3:0], ~m_frame[p], ~m_pres[p], 1'b0, 16'd0);
        sweep("R8 table unchanged");

        // Back-to-back requests with writes interleaved
        for (int p = 0; p < 16; p++) begin
            step("R6 R2 interleave", 1'b1, p[3:0], 3'(7 - p % 8), 1'b1, 1'b1, {p[3:0], 12'hA5A});
            req("R3 interleave check", {p[3:0], 12'h5A5});
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule